// File: doc/BRIEF.md
# Dual-Style Host Register Bus Front End

This block is the slave side of an 8-bit microprocessor bus that reaches a 64-entry register space. A static style input chooses how the host signals an access. In the strobe style, chip select is combined with separate active-low read and write strobes. In the direction style, chip select is combined with a read/write direction line and an active-low data strobe. The host pins are asynchronous to the block clock. The block passes the access strobes through a two-flop synchroniser and detects their edges there. It then issues single-cycle register requests (address, write data, write enable, read enable) to a register file that sits outside the block.

The address arrives on dedicated address pins and is captured by an address latch enable. The latch follows the pins while the enable is high and holds on its falling edge. For multiplexed addressing, the board ties the address pins to the low six data lines and the host pulses the enable. For dedicated addressing, the enable is tied high. Read data goes back through a data output and an output-enable, which form a tristate pad at the chip edge. The parallel bus is inactive when the hardware-mode strap is 1. It is also inactive when the style input and both strobes are low together, because that combination hands the pins to a serial interface. This condition is reported on its own output.

Top module: `hostbus_if`

## Requirements
- R1: After reset, reg_we and reg_re are 0, data_oe is 0 and reg_addr is 0.
- R2: In strobe style (style_sel = 0, rd_dir used as active-low read strobe, wr_ds_n as active-low write strobe), exactly one reg_we pulse is issued per write. It is issued only after wr_ds_n returns high and carries the latched address and the data present while the strobe was low.
- R3: In direction style (style_sel = 1), a write is rd_dir = 0 with wr_ds_n (data strobe) low. It commits exactly one reg_we pulse after the data strobe returns high, with the latched address and the data.
- R4: Each read access produces exactly one single-cycle reg_re pulse with reg_addr equal to the latched address. A read is rd_dir low in strobe style, or rd_dir = 1 with the data strobe low in direction style. While the read stays active, data_out shows the reg_rdata returned for that address.
- R5: data_oe is 1 only while cs_n is low and a read access is active. It is 0 during writes and in idle.
- R6: With multiplexed addressing, the address is the value on addr_in when ale falls. Later changes on addr_in are ignored.
- R7: With ale held high, the address is taken directly from addr_in.
- R8: When hw_strap is 1, strobes produce no reg_we or reg_re and data_oe stays 0.
- R9: When style_sel, rd_dir and wr_ds_n are all 0, serial_sel is 1, no request is issued and data_oe stays 0. Otherwise serial_sel is 0.
- R10: Strobes with cs_n high produce no request and no data drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hw_strap | input | 1 | Hardware-mode strap; 0 enables the host bus |
| style_sel | input | 1 | 0 = read/write strobes, 1 = direction line plus data strobe |
| cs_n | input | 1 | Active-low chip select |
| rd_dir | input | 1 | Read strobe (active low) or direction (1 = read) |
| wr_ds_n | input | 1 | Write strobe or data strobe, active low |
| ale | input | 1 | Address latch enable, transparent high |
| addr_in | input | 6 | Address pins (tied to data bits 5:0 when multiplexed) |
| data_in | input | 8 | Data bus input side |
| data_out | output | 8 | Data bus read value |
| data_oe | output | 1 | Data bus output enable |
| serial_sel | output | 1 | Pins handed to the serial interface |
| reg_addr | output | 6 | Register request address |
| reg_wdata | output | 8 | Register write data |
| reg_we | output | 1 | Single-cycle write request |
| reg_re | output | 1 | Single-cycle read request |
| reg_rdata | input | 8 | Read data from the register file for reg_addr |

## Verification
Reads and writes run in both strobe styles, each with multiplexed and with dedicated addressing. This separates a wrong strobe decode in one style from an address-capture fault in one addressing mode. In multiplexed accesses the address pins are moved to the data value after the enable falls, so a latch that stays transparent shows up as a wrong address. Write-enable counts are compared before and after strobe release, which exposes a commit on the wrong edge or a double commit. Strobes are also applied with chip select high, with the strap set, and in the serial-select combination; each of these must leave counts and drive unchanged.

// File: rtl/hbif_pkg.sv
package hbif_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 6;

    typedef enum logic [0:0] {
        STYLE_STROBES = 1'b0,
        STYLE_DIR_DS  = 1'b1
    } bus_style_e;

    typedef struct packed {
        logic              we;
        logic              re;
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] wa;
        logic [DATA_W-1:0] wd;
        logic [DATA_W-1:0] rdata;
    } req_state_t;
endpackage

// File: rtl/hbif_sync.sv
module hbif_sync #(
    parameter int N      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_in,
    output logic [N-1:0] cur,
    output logic [N-1:0] prv
);
    localparam int DEPTH = STAGES + 1;

    logic [N-1:0] stg_q [DEPTH];
    logic [N-1:0] stg_d [DEPTH];

    always_comb begin
        stg_d[0] = async_in;
        for (int i = 1; i < DEPTH; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                stg_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                stg_q[i] <= stg_d[i];
            end
        end
    end

    assign cur = stg_q[STAGES-1];
    assign prv = stg_q[STAGES];
endmodule

// File: rtl/hbif_addr_latch.sv
module hbif_addr_latch #(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ale,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_eff
);
    logic [ADDR_W-1:0] addr_d, addr_q;

    always_comb begin
        addr_d = ale ? addr_in : addr_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) addr_q <= '0;
        else        addr_q <= addr_d;
    end

    // transparent while the enable is high, held value afterwards
    assign addr_eff = ale ? addr_in : addr_q;
endmodule

// File: rtl/hostbus_if.sv
module hostbus_if
    import hbif_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hw_strap,
    input  logic              style_sel,
    input  logic              cs_n,
    input  logic              rd_dir,
    input  logic              wr_ds_n,
    input  logic              ale,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe,
    output logic              serial_sel,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_we,
    output logic              reg_re,
    input  logic [DATA_W-1:0] reg_rdata
);
    localparam int WR_IDX = 0;
    localparam int RD_IDX = 1;

    logic              par_on;
    logic              wr_raw, rd_raw;
    logic [1:0]        s_cur, s_prv;
    logic [ADDR_W-1:0] addr_eff;
    req_state_t        st_d, st_q;

    // mode decode (R8, R9)
    assign serial_sel = !hw_strap && (style_sel == STYLE_STROBES) && !rd_dir && !wr_ds_n;
    assign par_on     = !hw_strap && !serial_sel;

    // raw access decode from the asynchronous pins
    always_comb begin
        if (style_sel == STYLE_DIR_DS) begin
            wr_raw = par_on && !cs_n && !wr_ds_n && !rd_dir;
            rd_raw = par_on && !cs_n && !wr_ds_n &&  rd_dir;
        end else begin
            wr_raw = par_on && !cs_n && !wr_ds_n;
            rd_raw = par_on && !cs_n && !rd_dir;
        end
    end

    hbif_sync #(.N(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({rd_raw, wr_raw}),
        .cur      (s_cur),
        .prv      (s_prv)
    );

    hbif_addr_latch #(.ADDR_W(ADDR_W)) u_alat (
        .clk      (clk),
        .rst_n    (rst_n),
        .ale      (ale),
        .addr_in  (addr_in),
        .addr_eff (addr_eff)
    );

    always_comb begin
        st_d    = st_q;
        // write commits on the trailing edge of the synchronised strobe
        st_d.we = s_prv[WR_IDX] && !s_cur[WR_IDX];
        // read request on the leading edge
        st_d.re = s_cur[RD_IDX] && !s_prv[RD_IDX];
        if (s_cur[WR_IDX]) begin
            st_d.wa = addr_eff;
            st_d.wd = data_in;
        end
        if (st_d.re) begin
            st_d.addr = addr_eff;
        end else if (st_d.we) begin
            st_d.addr = st_q.wa;
        end
        if (st_q.re) begin
            st_d.rdata = reg_rdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign reg_we    = st_q.we;
    assign reg_re    = st_q.re;
    assign reg_addr  = st_q.addr;
    assign reg_wdata = st_q.wd;
    assign data_out  = st_q.rdata;
    assign data_oe   = rd_raw;
endmodule

// File: rtl/hbif_checker.sv
module hbif_checker (
    input logic clk,
    input logic rst_n,
    input logic hw_strap,
    input logic cs_n,
    input logic serial_sel,
    input logic reg_we,
    input logic reg_re,
    input logic data_oe
);
    a_r2_we_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);

    a_r4_re_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        reg_re |=> !reg_re);

    a_r4_we_re_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && reg_re));

    a_r5_no_drive_without_cs: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !data_oe);

    a_r8_strap_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        hw_strap |-> !data_oe);

    a_r9_serial_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        serial_sel |-> !data_oe);
endmodule

bind hostbus_if hbif_checker u_hbif_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .hw_strap   (hw_strap),
    .cs_n       (cs_n),
    .serial_sel (serial_sel),
    .reg_we     (reg_we),
    .reg_re     (reg_re),
    .data_oe    (data_oe)
);

// File: tb/tb_hostbus_if.sv
module tb_hostbus_if;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hw_strap = 1'b0;
    logic       style_sel = 1'b0;
    logic       cs_n = 1'b1;
    logic       rd_dir = 1'b1;
    logic       wr_ds_n = 1'b1;
    logic       ale = 1'b1;
    logic       mux_mode = 1'b0;
    logic [5:0] addr_drv = '0;
    logic [5:0] addr_in;
    logic [7:0] data_in = '0;
    logic [7:0] data_out, reg_wdata, reg_rdata;
    logic [5:0] reg_addr;
    logic       data_oe, serial_sel, reg_we, reg_re;

    int checks = 0;
    int errors = 0;
    int we_cnt = 0;
    int re_cnt = 0;
    logic [5:0] last_wa = '0, last_ra = '0;
    logic [7:0] last_wd = '0;

    always #5 clk = ~clk;

    // board wiring: multiplexed mode ties address pins to data bits 5:0
    assign addr_in = mux_mode ? data_in[5:0] : addr_drv;

    function automatic logic [7:0] rmodel(input logic [5:0] a);
        return {a, 2'b10} ^ 8'h3C;
    endfunction
    assign reg_rdata = rmodel(reg_addr);

    hostbus_if dut (
        .clk(clk), .rst_n(rst_n), .hw_strap(hw_strap), .style_sel(style_sel),
        .cs_n(cs_n), .rd_dir(rd_dir), .wr_ds_n(wr_ds_n), .ale(ale),
        .addr_in(addr_in), .data_in(data_in), .data_out(data_out),
        .data_oe(data_oe), .serial_sel(serial_sel), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_re(reg_re),
        .reg_rdata(reg_rdata)
    );

    always @(posedge clk) begin
        if (reg_we) begin
            we_cnt  <= we_cnt + 1;
            last_wa <= reg_addr;
            last_wd <= reg_wdata;
        end
        if (reg_re) begin
            re_cnt  <= re_cnt + 1;
            last_ra <= reg_addr;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s got %0h exp %0h", tag, got, exp);
        end
    endtask

    // {style, mux, write, addr[5:0], data[7:0]}
    localparam logic [16:0] VEC [8] = '{
        {1'b0, 1'b0, 1'b1, 6'h05, 8'hA5},
        {1'b0, 1'b0, 1'b0, 6'h05, 8'h00},
        {1'b0, 1'b1, 1'b1, 6'h3F, 8'h12},
        {1'b0, 1'b1, 1'b0, 6'h21, 8'h00},
        {1'b1, 1'b0, 1'b1, 6'h00, 8'hFF},
        {1'b1, 1'b0, 1'b0, 6'h2A, 8'h00},
        {1'b1, 1'b1, 1'b1, 6'h1C, 8'hC3},
        {1'b1, 1'b1, 1'b0, 6'h3F, 8'h00}
    };

    task automatic access(input logic sty, input logic mx, input logic wr,
                          input logic [5:0] a, input logic [7:0] d);
        int we0, re0;
        string wtag, atag;
        wtag = sty ? "R3" : "R2";
        atag = mx ? "R6" : "R7";
        @(negedge clk);
        style_sel = sty; mux_mode = mx; rd_dir = 1'b1; wr_ds_n = 1'b1; cs_n = 1'b1;
        if (mx) begin
            ale = 1'b1; data_in = {2'b00, a};
            repeat (2) @(negedge clk);
            ale = 1'b0;
            @(negedge clk);
            data_in = wr ? d : 8'hFF;   // address pins now move away from a
        end else begin
            ale = 1'b1; addr_drv = a; data_in = wr ? d : 8'h00;
        end
        we0 = we_cnt; re0 = re_cnt;
        cs_n = 1'b0;
        @(negedge clk);
        if (sty) begin
            rd_dir = !wr;
            @(negedge clk);
            wr_ds_n = 1'b0;
        end else if (wr) begin
            wr_ds_n = 1'b0;
        end else begin
            rd_dir = 1'b0;
        end
        repeat (6) @(negedge clk);
        if (wr) begin
            chk(we_cnt == we0, {wtag, " no commit before strobe release"}, we_cnt, we0);
            chk(data_oe == 1'b0, "R5 no drive during write", data_oe, 0);
        end else begin
            chk(re_cnt == re0 + 1, "R4 one read request", re_cnt, re0 + 1);
            chk(last_ra == a, {atag, " read address"}, last_ra, a);
            chk(data_oe == 1'b1, "R5 drive during read", data_oe, 1);
            chk(data_out == rmodel(a), "R4 read data", data_out, rmodel(a));
        end
        rd_dir = 1'b1; wr_ds_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(data_oe == 1'b0, "R5 released after access", data_oe, 0);
        if (wr) begin
            chk(we_cnt == we0 + 1, {wtag, " one commit"}, we_cnt, we0 + 1);
            chk(last_wa == a, {atag, " write address"}, last_wa, a);
            chk(last_wd == d, {wtag, " write data"}, last_wd, d);
        end else begin
            chk(re_cnt == re0 + 1, "R4 no extra read request", re_cnt, re0 + 1);
        end
        cs_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic quiet_probe(input string tag);
        int we0, re0;
        we0 = we_cnt; re0 = re_cnt;
        repeat (6) @(negedge clk);
        chk(data_oe == 1'b0, {tag, " no drive"}, data_oe, 0);
        rd_dir = 1'b1; wr_ds_n = 1'b1;
        repeat (6) @(negedge clk);
        chk(we_cnt == we0 && re_cnt == re0, {tag, " no request"}, we_cnt + re_cnt, we0 + re0);
        cs_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(reg_we == 1'b0 && reg_re == 1'b0, "R1 requests idle in reset", {reg_we, reg_re}, 0);
        chk(data_oe == 1'b0, "R1 no drive in reset", data_oe, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(reg_addr == 6'd0, "R1 address after reset", reg_addr, 0);
        chk(serial_sel == 1'b0, "R9 serial_sel low when idle", serial_sel, 0);

        for (int i = 0; i < 8; i++) begin
            access(VEC[i][16], VEC[i][15], VEC[i][14], VEC[i][13:8], VEC[i][7:0]);
        end

        // R10: strobes with chip select high
        style_sel = 1'b0; mux_mode = 1'b0; ale = 1'b1; addr_drv = 6'h11;
        @(negedge clk);
        rd_dir = 1'b0;
        quiet_probe("R10 read strobe cs high");
        @(negedge clk);
        wr_ds_n = 1'b0;
        quiet_probe("R10 write strobe cs high");

        // R8: hardware strap set
        hw_strap = 1'b1; cs_n = 1'b0;
        @(negedge clk);
        rd_dir = 1'b0;
        quiet_probe("R8 read with strap");
        hw_strap = 1'b0;

        // R9: serial selection combination
        cs_n = 1'b0; style_sel = 1'b0;
        @(negedge clk);
        rd_dir = 1'b0; wr_ds_n = 1'b0;
        @(negedge clk);
        chk(serial_sel == 1'b1, "R9 serial_sel asserted", serial_sel, 1);
        quiet_probe("R9 serial combination");
        chk(serial_sel == 1'b0, "R9 serial_sel released", serial_sel, 0);

        // parallel bus still works afterwards
        access(1'b0, 1'b1, 1'b1, 6'h2D, 8'h5E);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired got 0 exp 1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule